// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage stage of one programmable-logic macrocell. It takes the sum from the product-term allocator, or a direct pin input when fast input registering is wanted. It passes that bit through a programmable XOR stage and either presents it combinationally or holds it in a storage element. The element is configured as an edge-triggered D flip-flop, an edge-triggered toggle flip-flop, or a level-sensitive transparent latch.

The element's clock is picked by an eight-way selector. The selector offers four block-wide clocks, a product-term clock shared across the block, the inverse of that shared clock, and both polarities of a product-term clock private to this macrocell. Asynchronous initialization merges three terms: the shared one, a private one, and a dual-purpose term that a configuration bit turns into a clock enable instead. A power-up event loads a configured value and outranks every other source.

Top module: `mc_cell`

## Requirements
- R1: While `pwr_init` is high, the output (in modes other than combinational) equals `pwr_val`, and it keeps that value after `pwr_init` falls until another event changes it.
- R2: `clk_sel` picks the element's clock: 0 to 3 are `blk_clk[0..3]`, 4 is `sh_pt_clk`, 5 is the inverse of `sh_pt_clk`, 6 is `ind_pt_clk` and 7 is its inverse. A rising edge on any source other than the selected one leaves the output unchanged.
- R3: In mode 0 (D), each rising edge of the selected clock with the enable active loads the data bit, and the output holds between edges.
- R4: In mode 1 (T), a rising edge with the enable active inverts the output when the data bit is 1 and leaves it unchanged when the data bit is 0.
- R5: In mode 2 (latch), the output follows the data bit while the selected clock is high and the enable is active, and it holds the last value while the clock is low.
- R6: The data bit is the selected source XORed with `xor_pol` when `xor_use_pt` is 0, or with `single_pt` when `xor_use_pt` is 1.
- R7: Raising `sh_init`, `ind_init`, or `dual_term` with `dual_is_ce` = 0 forces the element at once, with no clock edge, to 1 when `init_to_set` = 1 or to 0 when it is 0. The element holds that value through clock edges for as long as the term stays high.
- R8: With `dual_is_ce` = 1, `dual_term` is a clock enable. When it is low, edges load nothing in D or T mode, and a high level on it never initializes the element.
- R9: With `use_io` = 1 the data source is `io_in` rather than `alloc_sum`.
- R10: In mode 3 (combinational), `mc_out` equals the data bit at all times, without any clock.
- R11: `pwr_init` outranks the initialization terms: while it is high, the output is `pwr_val` even when an initialization term calls for the opposite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwr_init | input | 1 | Power-up initialization event, active high, asynchronous |
| pwr_val | input | 1 | Value loaded by the power-up event |
| blk_clk | input | 4 | Block-wide clocks, sources 0 to 3 |
| sh_pt_clk | input | 1 | Shared product-term clock (sources 4 and 5) |
| ind_pt_clk | input | 1 | Private product-term clock (sources 6 and 7) |
| clk_sel | input | 3 | Clock source select |
| alloc_sum | input | 1 | Sum from the product-term allocator |
| io_in | input | 1 | Direct input from the pin cell |
| use_io | input | 1 | 1 selects `io_in` as the data source |
| xor_use_pt | input | 1 | 1 selects `single_pt` as the XOR operand |
| xor_pol | input | 1 | Fixed polarity XOR operand |
| single_pt | input | 1 | Single product term XOR operand |
| mode | input | 2 | 0 D, 1 T, 2 latch, 3 combinational |
| sh_init | input | 1 | Shared initialization term |
| ind_init | input | 1 | Private initialization term |
| dual_term | input | 1 | Term used as initialization or clock enable |
| dual_is_ce | input | 1 | 1 makes `dual_term` a clock enable |
| init_to_set | input | 1 | 1 makes initialization set, 0 makes it clear |
| mc_out | output | 1 | Result toward output and global routing |

## Verification
An asynchronous initialization and a rising edge of the selected clock can land together. The bench provokes this by holding an initialization term high across a full clock pulse whose data calls for the opposite value. It judges the result from the port: the initialized value must hold through the edge, and the data must load only on the first edge after the term drops. A second collision puts the power-up event against an initialization term of the opposite sense, where the bench expects the power-up value to win.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  typedef enum logic [1:0] {
    MC_DFF   = 2'd0,
    MC_TFF   = 2'd1,
    MC_LATCH = 2'd2,
    MC_COMB  = 2'd3
  } mc_mode_e;

  // Data bit after the polarity stage.
  function automatic logic mc_polarity(input logic src, input logic use_pt,
                                       input logic pol, input logic pt);
    return src ^ (use_pt ? pt : pol);
  endfunction

  // Next value of the edge-triggered element.
  function automatic logic mc_next_state(input mc_mode_e m, input logic q,
                                         input logic d, input logic ce);
    if (!ce) return q;
    if (m == MC_TFF) return q ^ d;
    return d;
  endfunction

endpackage

// File: rtl/mc_clk_sel.sv
`timescale 1ns/1ps
module mc_clk_sel #(
  parameter int NUM_BLK_CLK = 4,
  parameter int SEL_W       = $clog2(NUM_BLK_CLK + 4)
) (
  input  logic [NUM_BLK_CLK-1:0] blk_clk,
  input  logic                   sh_pt_clk,
  input  logic                   ind_pt_clk,
  input  logic [SEL_W-1:0]       sel,
  output logic                   sel_clk
);
  localparam int NSRC  = NUM_BLK_CLK + 4;
  localparam int NSLOT = 1 << SEL_W;

  logic [NSLOT-1:0] src;

  genvar b;
  generate
    for (b = 0; b < NUM_BLK_CLK; b++) begin : g_blk
      assign src[b] = blk_clk[b];
    end
    for (b = NSRC; b < NSLOT; b++) begin : g_pad
      assign src[b] = 1'b0;
    end
  endgenerate

  assign src[NUM_BLK_CLK]     = sh_pt_clk;
  assign src[NUM_BLK_CLK + 1] = ~sh_pt_clk;
  assign src[NUM_BLK_CLK + 2] = ind_pt_clk;
  assign src[NUM_BLK_CLK + 3] = ~ind_pt_clk;

  assign sel_clk = src[sel];
endmodule

// File: rtl/mc_data_path.sv
`timescale 1ns/1ps
module mc_data_path
  import mc_pkg::*;
(
  input  logic alloc_sum,
  input  logic io_in,
  input  logic use_io,
  input  logic xor_use_pt,
  input  logic xor_pol,
  input  logic single_pt,
  output logic d_in
);
  logic src_bit;
  assign src_bit = use_io ? io_in : alloc_sum;
  assign d_in    = mc_polarity(src_bit, xor_use_pt, xor_pol, single_pt);
endmodule

// File: rtl/mc_init_merge.sv
`timescale 1ns/1ps
module mc_init_merge (
  input  logic pwr_init,
  input  logic pwr_val,
  input  logic sh_init,
  input  logic ind_init,
  input  logic dual_term,
  input  logic dual_is_ce,
  input  logic init_to_set,
  output logic init_any,
  output logic clk_en,
  output logic async_set,
  output logic async_rst
);
  assign init_any  = sh_init | ind_init | (dual_term & ~dual_is_ce);
  assign clk_en    = dual_is_ce ? dual_term : 1'b1;
  // Power-up outranks the initialization terms.
  assign async_set = pwr_init ? pwr_val  : (init_any & init_to_set);
  assign async_rst = pwr_init ? ~pwr_val : (init_any & ~init_to_set);
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
  import mc_pkg::*;
(
  input  logic     sel_clk,
  input  logic     async_set,
  input  logic     async_rst,
  input  logic     clk_en,
  input  mc_mode_e mode,
  input  logic     d_in,
  output logic     mc_out
);
  logic flop_q;
  logic latch_q;
  logic async_on;

  assign async_on = async_set | async_rst;

  always_ff @(posedge sel_clk or posedge async_rst or posedge async_set) begin
    if (async_rst)      flop_q <= 1'b0;
    else if (async_set) flop_q <= 1'b1;
    else                flop_q <= mc_next_state(mode, flop_q, d_in, clk_en);
  end

  always_latch begin
    if (async_rst)               latch_q <= 1'b0;
    else if (async_set)          latch_q <= 1'b1;
    else if (sel_clk && clk_en)  latch_q <= d_in;
  end

  always_comb begin
    case (mode)
      MC_COMB:  mc_out = d_in;
      MC_LATCH: mc_out = latch_q;
      default:  mc_out = flop_q;
    endcase
  end

  // At the falling edge of the selected clock the flop holds what the rising
  // edge loaded (inputs are held steady over the high phase).
  p_dff_capture_r3: assert property (@(negedge sel_clk) disable iff (async_on)
    (mode == MC_DFF && clk_en) |-> (flop_q == d_in))
    else $error("R3 D capture mismatch");

  // The latch closes on the falling edge holding the data it followed.
  p_latch_follow_r5: assert property (@(negedge sel_clk) disable iff (async_on)
    (mode == MC_LATCH && clk_en) |-> (latch_q == d_in))
    else $error("R5 latch follow mismatch");
endmodule

// File: rtl/mc_cell.sv
`timescale 1ns/1ps
module mc_cell
  import mc_pkg::*;
#(
  parameter int NUM_BLK_CLK = 4
) (
  input  logic                                pwr_init,
  input  logic                                pwr_val,
  input  logic [NUM_BLK_CLK-1:0]              blk_clk,
  input  logic                                sh_pt_clk,
  input  logic                                ind_pt_clk,
  input  logic [$clog2(NUM_BLK_CLK + 4)-1:0]  clk_sel,
  input  logic                                alloc_sum,
  input  logic                                io_in,
  input  logic                                use_io,
  input  logic                                xor_use_pt,
  input  logic                                xor_pol,
  input  logic                                single_pt,
  input  logic [1:0]                          mode,
  input  logic                                sh_init,
  input  logic                                ind_init,
  input  logic                                dual_term,
  input  logic                                dual_is_ce,
  input  logic                                init_to_set,
  output logic                                mc_out
);
  localparam int SEL_W = $clog2(NUM_BLK_CLK + 4);

  mc_mode_e mode_e;
  logic     sel_clk;
  logic     d_in;
  logic     init_any;
  logic     clk_en;
  logic     async_set;
  logic     async_rst;

  assign mode_e = mc_mode_e'(mode);

  mc_clk_sel #(.NUM_BLK_CLK(NUM_BLK_CLK), .SEL_W(SEL_W)) u_clk_sel (
    .blk_clk    (blk_clk),
    .sh_pt_clk  (sh_pt_clk),
    .ind_pt_clk (ind_pt_clk),
    .sel        (clk_sel),
    .sel_clk    (sel_clk)
  );

  mc_data_path u_data (
    .alloc_sum  (alloc_sum),
    .io_in      (io_in),
    .use_io     (use_io),
    .xor_use_pt (xor_use_pt),
    .xor_pol    (xor_pol),
    .single_pt  (single_pt),
    .d_in       (d_in)
  );

  mc_init_merge u_init (
    .pwr_init    (pwr_init),
    .pwr_val     (pwr_val),
    .sh_init     (sh_init),
    .ind_init    (ind_init),
    .dual_term   (dual_term),
    .dual_is_ce  (dual_is_ce),
    .init_to_set (init_to_set),
    .init_any    (init_any),
    .clk_en      (clk_en),
    .async_set   (async_set),
    .async_rst   (async_rst)
  );

  mc_store u_store (
    .sel_clk   (sel_clk),
    .async_set (async_set),
    .async_rst (async_rst),
    .clk_en    (clk_en),
    .mode      (mode_e),
    .d_in      (d_in),
    .mc_out    (mc_out)
  );

  // A held clear term keeps the stored output at 0 across clock edges.
  p_init_clear_r7: assert property (@(negedge sel_clk) disable iff (pwr_init)
    (init_any && !init_to_set && mode_e != MC_COMB) |-> (mc_out == 1'b0))
    else $error("R7 init clear not held");

  // A held set term keeps the stored output at 1 across clock edges.
  p_init_set_r7: assert property (@(negedge sel_clk) disable iff (pwr_init)
    (init_any && init_to_set && mode_e != MC_COMB) |-> (mc_out == 1'b1))
    else $error("R7 init set not held");
endmodule

// File: tb/tb_mc_cell.sv
`timescale 1ns/1ps
module tb_mc_cell;
  logic       clk = 1'b0;
  logic       pwr_init, pwr_val;
  logic [3:0] blk_clk;
  logic       sh_pt_clk, ind_pt_clk;
  logic [2:0] clk_sel;
  logic       alloc_sum, io_in, use_io, xor_use_pt, xor_pol, single_pt;
  logic [1:0] mode;
  logic       sh_init, ind_init, dual_term, dual_is_ce, init_to_set;
  logic       mc_out;

  int n_checks = 0;
  int n_errors = 0;
  int cur_src  = 0;

  localparam logic [1:0] M_D = 2'd0, M_T = 2'd1, M_L = 2'd2, M_C = 2'd3;

  always #10 clk = ~clk;

  mc_cell dut (
    .pwr_init(pwr_init), .pwr_val(pwr_val), .blk_clk(blk_clk),
    .sh_pt_clk(sh_pt_clk), .ind_pt_clk(ind_pt_clk), .clk_sel(clk_sel),
    .alloc_sum(alloc_sum), .io_in(io_in), .use_io(use_io),
    .xor_use_pt(xor_use_pt), .xor_pol(xor_pol), .single_pt(single_pt),
    .mode(mode), .sh_init(sh_init), .ind_init(ind_init),
    .dual_term(dual_term), .dual_is_ce(dual_is_ce),
    .init_to_set(init_to_set), .mc_out(mc_out)
  );

  task automatic check(input logic exp, input string req, input string what);
    n_checks++;
    if (mc_out !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, mc_out, exp);
    end
  endtask

  // Drive the raw clock behind a source so that the source reads lvl.
  task automatic set_level(input int src, input logic lvl);
    case (src)
      0, 1, 2, 3: blk_clk[src] = lvl;
      4: sh_pt_clk  = lvl;
      5: sh_pt_clk  = ~lvl;
      6: ind_pt_clk = lvl;
      default: ind_pt_clk = ~lvl;
    endcase
  endtask

  task automatic pulse_src(input int src);
    @(posedge clk); set_level(src, 1'b1);
    @(negedge clk); set_level(src, 1'b0);
    #5;
  endtask

  task automatic pulse();
    pulse_src(cur_src);
  endtask

  // Power-up into a fresh configuration; every source reads low.
  task automatic setup(input int src, input logic [1:0] md, input logic pv);
    @(negedge clk);
    pwr_init = 1'b1; pwr_val = pv; mode = md; clk_sel = 3'(src);
    cur_src = src;
    blk_clk = 4'b0; sh_pt_clk = 1'b1; ind_pt_clk = 1'b1;
    sh_pt_clk = 1'b0; ind_pt_clk = 1'b0;
    set_level(5, 1'b0); set_level(7, 1'b0);
    if (src == 4) sh_pt_clk = 1'b0;
    if (src == 6) ind_pt_clk = 1'b0;
    sh_init = 0; ind_init = 0; dual_term = 0; dual_is_ce = 0; init_to_set = 0;
    alloc_sum = 0; io_in = 0; use_io = 0; xor_use_pt = 0; xor_pol = 0; single_pt = 0;
    #4 pwr_init = 1'b0;
    #3;
  endtask

  task automatic t_powerup();
    setup(0, M_D, 1'b1); check(1'b1, "R1", "power-up value 1");
    setup(0, M_D, 1'b0); check(1'b0, "R1", "power-up value 0");
    setup(2, M_L, 1'b1); check(1'b1, "R1", "power-up value in latch mode");
  endtask

  task automatic t_pwr_priority();
    setup(0, M_D, 1'b0);
    @(negedge clk);
    pwr_init = 1; pwr_val = 1; init_to_set = 0; sh_init = 1;
    #3 check(1'b1, "R11", "power-up 1 beats clear term");
    pwr_val = 0; sh_init = 0; init_to_set = 1; ind_init = 1;
    #3 check(1'b0, "R11", "power-up 0 beats set term");
    ind_init = 0; #2 pwr_init = 0; #3;
    check(1'b0, "R1", "value kept after power-up released");
  endtask

  task automatic t_dff();
    setup(0, M_D, 1'b0);
    alloc_sum = 1; #3 check(1'b0, "R3", "holds before edge");
    pulse(); check(1'b1, "R3", "loads 1");
    alloc_sum = 0; #3 check(1'b1, "R3", "holds between edges");
    pulse(); check(1'b0, "R3", "loads 0");
    alloc_sum = 1; pulse(); check(1'b1, "R3", "loads 1 again");
  endtask

  task automatic t_clk_mux();
    for (int s = 0; s < 8; s++) begin
      setup(s, M_D, 1'b0);
      alloc_sum = 1;
      pulse_src((s + 4) % 8);
      check(1'b0, "R2", $sformatf("unselected edge ignored, sel %0d", s));
      pulse();
      check(1'b1, "R2", $sformatf("selected edge loads, sel %0d", s));
    end
  endtask

  task automatic t_tff();
    setup(3, M_T, 1'b0);
    alloc_sum = 1;
    pulse(); check(1'b1, "R4", "toggle to 1");
    pulse(); check(1'b0, "R4", "toggle to 0");
    alloc_sum = 0;
    pulse(); check(1'b0, "R4", "hold with data 0");
    alloc_sum = 1;
    pulse(); check(1'b1, "R4", "toggle after hold");
  endtask

  task automatic t_latch();
    setup(0, M_L, 1'b0);
    alloc_sum = 1; #3 check(1'b0, "R5", "closed while clock low");
    @(posedge clk); set_level(0, 1'b1);
    #3 check(1'b1, "R5", "transparent while high");
    alloc_sum = 0; #3 check(1'b0, "R5", "follows fall while high");
    alloc_sum = 1; #3 check(1'b1, "R5", "follows rise while high");
    @(negedge clk); set_level(0, 1'b0);
    #3 alloc_sum = 0;
    #3 check(1'b1, "R5", "holds after clock falls");
  endtask

  task automatic t_xor_comb();
    setup(0, M_C, 1'b0);
    for (int v = 0; v < 16; v++) begin
      alloc_sum = v[0]; xor_use_pt = v[1]; xor_pol = v[2]; single_pt = v[3];
      #3 check(v[0] ^ (v[1] ? v[3] : v[2]), "R6",
               $sformatf("polarity stage, combinational (R10) pattern %0d", v));
    end
    setup(0, M_D, 1'b0);
    alloc_sum = 1; xor_use_pt = 0; xor_pol = 1;
    pulse(); check(1'b0, "R6", "inverted data stored");
    xor_use_pt = 1; single_pt = 0;
    pulse(); check(1'b1, "R6", "single term operand stored");
  endtask

  task automatic t_io();
    setup(1, M_D, 1'b0);
    use_io = 1; io_in = 1; alloc_sum = 0;
    pulse(); check(1'b1, "R9", "pin input 1 used");
    io_in = 0; alloc_sum = 1;
    pulse(); check(1'b0, "R9", "pin input 0 used");
    use_io = 0;
    pulse(); check(1'b1, "R9", "allocator sum back in use");
  endtask

  task automatic t_init();
    setup(0, M_D, 1'b0);
    init_to_set = 1; sh_init = 1;
    #3 check(1'b1, "R7", "shared term sets without clock");
    alloc_sum = 0;
    pulse(); check(1'b1, "R7", "set held across clock edge");
    sh_init = 0; #3;
    pulse(); check(1'b0, "R7", "data loads after release");
    alloc_sum = 1; pulse();
    init_to_set = 0; ind_init = 1;
    #3 check(1'b0, "R7", "private term clears");
    ind_init = 0; #3;
    pulse(); check(1'b1, "R7", "load after private release");
    dual_is_ce = 0; dual_term = 1;
    #3 check(1'b0, "R7", "dual term clears as init");
    dual_term = 0; #3;
  endtask

  task automatic t_ce();
    setup(0, M_D, 1'b0);
    dual_is_ce = 1; dual_term = 0; alloc_sum = 1; init_to_set = 1;
    pulse(); check(1'b0, "R8", "enable low blocks D load");
    dual_term = 1;
    pulse(); check(1'b1, "R8", "enable high allows D load");
    init_to_set = 0; #3;
    check(1'b1, "R8", "dual term high does not initialize");
    dual_term = 0; alloc_sum = 0;
    pulse(); check(1'b1, "R8", "D holds with enable low");
    setup(0, M_T, 1'b0);
    dual_is_ce = 1; dual_term = 0; alloc_sum = 1;
    pulse(); check(1'b0, "R8", "enable low blocks toggle");
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    pwr_init = 1; pwr_val = 0; blk_clk = 0; sh_pt_clk = 0; ind_pt_clk = 0;
    clk_sel = 0; alloc_sum = 0; io_in = 0; use_io = 0; xor_use_pt = 0;
    xor_pol = 0; single_pt = 0; mode = 0; sh_init = 0; ind_init = 0;
    dual_term = 0; dual_is_ce = 0; init_to_set = 0;
    repeat (2) @(negedge clk);
    t_powerup();
    t_pwr_priority();
    t_dff();
    t_clk_mux();
    t_tff();
    t_latch();
    t_xor_comb();
    t_io();
    t_init();
    t_ce();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule